// File: doc/BRIEF.md
# Trace Timing Packet Scheduler

This block decides when timing packets enter a hardware trace stream and what each one carries. It watches three time sources: a free-running timestamp counter, a slower crystal-clock counter, and the core clock, which it counts itself. From these it raises three kinds of request:

- a full timestamp packet, carrying the whole timestamp counter;
- a mini time packet, carrying a short slice of the crystal counter;
- a cycle packet, carrying the number of core clocks since the previous one.

Each kind has its own enable. All three are gated by a global trace enable.

A small state machine arbitrates between pending requests. It moves the winner into an output register and presents it on a valid/ready packet port as a type code and a payload. States:

- `ST_IDLE`: nothing is presented.
- `ST_FULL`, `ST_MINI`, `ST_CYC`: one packet of that kind is held on the port.

Transitions:

- `LOAD_FULL`, `LOAD_MINI`, `LOAD_CYC` leave `ST_IDLE` when tracing is on and a request of that kind wins arbitration.
- `ACCEPT` returns to `ST_IDLE` when ready is high.

A packet is presented at the earliest one cycle after its request becomes pending. Back-to-back packets are separated by one idle cycle. Turning the packets into bytes and merging them with flow packets happen downstream.

Top module: `trace_timing_sched`

## Requirements
- R1: After reset `pkt_valid` is low and stays low while tracing is off.
- R2: When `trace_en` rises while `full_en` is high, one packet with type code 1 is issued. Its payload is the value of `tsc` when the packet is loaded.
- R3: A `sync_req` pulse while `trace_en` and `full_en` are high requests one more type-1 packet.
- R4: With `mini_en` set, a change of bit `mini_sel` of `ctc` from one cycle to the next issues one packet with type code 2. Its payload is `ctc[mini_sel+7:mini_sel]`, with bits above the counter top read as zero. Changes in the other bits of `ctc` issue nothing.
- R5: With `cyc_en` set and `cyc_thresh` of 2 or more, the port never stalls and no other packet kind is requested. Under these conditions a type-3 packet is issued every `cyc_thresh` clocks, and its payload equals `cyc_thresh`.
- R6: The core-clock count saturates at all ones while a cycle packet waits. After a long stall, the next cycle packet carries the all-ones value.
- R7: When several requests are pending in the same cycle, they leave in this order: full timestamp, then mini time, then cycle.
- R8: While `pkt_valid` is high and `pkt_ready` is low, valid, type and payload hold their values. A presented packet is never withdrawn.
- R9: A kind whose enable is low issues no packets. This holds even when its trigger occurs.
- R10: While `trace_en` is low, no new packet is loaded and pending requests are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| trace_en | input | 1 | Global trace enable |
| full_en | input | 1 | Enable for full timestamp packets |
| mini_en | input | 1 | Enable for mini time packets |
| cyc_en | input | 1 | Enable for cycle packets |
| mini_sel | input | SEL_W | Crystal-counter bit watched for mini packets |
| cyc_thresh | input | CYC_W | Core clocks per cycle packet |
| sync_req | input | 1 | Request an extra full timestamp packet |
| tsc | input | TS_W | Free-running timestamp counter |
| ctc | input | CRY_W | Crystal-clock counter |
| pkt_ready | input | 1 | Downstream accepts the presented packet |
| pkt_valid | output | 1 | A packet is presented |
| pkt_type | output | 2 | 1 full timestamp, 2 mini time, 3 cycle |
| pkt_payload | output | TS_W | Packet payload, zero-extended |

## Verification
Some properties are checked by assertions on every cycle:

- the hold of a stalled packet;
- the arbitration order at each load;
- the silence of the port while tracing is off;
- the saturation of the core-clock count.

Other behaviour can only be shown by the bench's scenarios, because it depends on the values and counts of packets over time:

- payload values;
- the exact period of cycle packets;
- the all-ones value after a long stall;
- the absence of packets for a disabled kind or an unwatched crystal bit.

// File: rtl/trace_tsched_pkg.sv
package trace_tsched_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_FULL = 2'd1,
        PK_MINI = 2'd2,
        PK_CYC  = 2'd3
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FULL = 2'd1,
        ST_MINI = 2'd2,
        ST_CYC  = 2'd3
    } sched_state_e;

    localparam int MINI_PAY_W = 8;

endpackage

// File: rtl/tsched_full_req.sv
module tsched_full_req (
    input  logic clk,
    input  logic rst_n,
    input  logic trace_en,
    input  logic full_en,
    input  logic sync_req,
    input  logic take,
    output logic pend
);
    logic trace_q;
    logic armed;
    logic trig;

    assign armed = trace_en & full_en;
    assign trig  = armed & (~trace_q | sync_req);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trace_q <= 1'b0;
            pend    <= 1'b0;
        end else begin
            trace_q <= trace_en;
            if (!armed) begin
                pend <= 1'b0;
            end else begin
                pend <= trig | (pend & ~take);
            end
        end
    end
endmodule

// File: rtl/tsched_mini_req.sv
module tsched_mini_req #(
    parameter int CRY_W = 16,
    parameter int SEL_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic [SEL_W-1:0]      sel,
    input  logic [CRY_W-1:0]      ctc,
    input  logic                  take,
    output logic                  pend,
    output logic [7:0]            slice
);
    localparam int EXT_W = CRY_W + 8;

    logic [CRY_W-1:0] ctc_q;
    logic             flip;
    logic [EXT_W-1:0] ext;

    assign flip  = ctc[sel] ^ ctc_q[sel];
    assign ext   = {8'd0, ctc} >> sel;
    assign slice = ext[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctc_q <= '0;
            pend  <= 1'b0;
        end else begin
            ctc_q <= ctc;
            if (!arm) begin
                pend <= 1'b0;
            end else begin
                pend <= flip | (pend & ~take);
            end
        end
    end
endmodule

// File: rtl/tsched_cyc_count.sv
module tsched_cyc_count #(
    parameter int CYC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CYC_W-1:0] thresh,
    input  logic             take,
    output logic [CYC_W-1:0] cnt,
    output logic             due
);
    localparam logic [CYC_W-1:0] CNT_MAX = '1;
    localparam logic [CYC_W-1:0] CNT_ONE = CYC_W'(1);

    logic [CYC_W-1:0] eff_thr;

    assign eff_thr = (thresh == '0) ? CNT_ONE : thresh;
    assign due     = run && (cnt >= eff_thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= CNT_ONE;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    // R6: a saturated count stays saturated until a packet takes it
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !take && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/trace_timing_sched.sv
module trace_timing_sched
    import trace_tsched_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CRY_W = 16,
    parameter int CYC_W = 12,
    parameter int SEL_W = $clog2(CRY_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_en,
    input  logic             full_en,
    input  logic             mini_en,
    input  logic             cyc_en,
    input  logic [SEL_W-1:0] mini_sel,
    input  logic [CYC_W-1:0] cyc_thresh,
    input  logic             sync_req,
    input  logic [TS_W-1:0]  tsc,
    input  logic [CRY_W-1:0] ctc,
    input  logic             pkt_ready,
    output logic             pkt_valid,
    output logic [1:0]       pkt_type,
    output logic [TS_W-1:0]  pkt_payload
);
    localparam int PAD_MINI = TS_W - MINI_PAY_W;
    localparam int PAD_CYC  = TS_W - CYC_W;

    sched_state_e state, state_n;

    logic            full_pend, mini_pend, cyc_due;
    logic            take_full, take_mini, take_cyc;
    logic [7:0]      mini_slice;
    logic [CYC_W-1:0] cyc_cnt;
    logic            idle_on;
    pkt_kind_e       kind;

    assign idle_on   = (state == ST_IDLE) && trace_en;
    assign take_full = idle_on && full_pend;
    assign take_mini = idle_on && !full_pend && mini_pend;
    assign take_cyc  = idle_on && !full_pend && !mini_pend && cyc_due;

    tsched_full_req u_full (
        .clk      (clk),
        .rst_n    (rst_n),
        .trace_en (trace_en),
        .full_en  (full_en),
        .sync_req (sync_req),
        .take     (take_full),
        .pend     (full_pend)
    );

    tsched_mini_req #(.CRY_W(CRY_W), .SEL_W(SEL_W)) u_mini (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (trace_en & mini_en),
        .sel   (mini_sel),
        .ctc   (ctc),
        .take  (take_mini),
        .pend  (mini_pend),
        .slice (mini_slice)
    );

    tsched_cyc_count #(.CYC_W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (trace_en & cyc_en),
        .thresh (cyc_thresh),
        .take   (take_cyc),
        .cnt    (cyc_cnt),
        .due    (cyc_due)
    );

    // next state: LOAD_* out of idle, ACCEPT back to idle
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (take_full)      state_n = ST_FULL;
                else if (take_mini) state_n = ST_MINI;
                else if (take_cyc)  state_n = ST_CYC;
            end
            ST_FULL, ST_MINI, ST_CYC: begin
                if (pkt_ready) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_payload <= '0;
        end else if (take_full) begin
            pkt_payload <= tsc;
        end else if (take_mini) begin
            pkt_payload <= {{PAD_MINI{1'b0}}, mini_slice};
        end else if (take_cyc) begin
            pkt_payload <= {{PAD_CYC{1'b0}}, cyc_cnt};
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: kind = PK_NONE;
            ST_FULL: kind = PK_FULL;
            ST_MINI: kind = PK_MINI;
            ST_CYC:  kind = PK_CYC;
            default: kind = PK_NONE;
        endcase
    end

    assign pkt_valid = (state != ST_IDLE);
    assign pkt_type  = kind;

    // R8: stalled packet holds valid, type and payload
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=>
        (pkt_valid && $stable(pkt_type) && $stable(pkt_payload)));

    // R7: a pending full timestamp request wins the next load
    p_full_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trace_en && full_pend) |=>
        (pkt_valid && pkt_type == 2'd1));

    // R7: mini time beats cycle when no full timestamp is pending
    p_mini_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && trace_en && !full_pend && mini_pend) |=>
        (pkt_valid && pkt_type == 2'd2));

    // R10: nothing is loaded while tracing is off
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !trace_en) |=> !pkt_valid);

    // R8: a presented packet always has a legal type code
    p_legal_type_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_type != 2'd0));
endmodule

// File: tb/trace_timing_sched_tb.sv
module trace_timing_sched_tb;
    localparam int TS_W  = 32;
    localparam int CRY_W = 16;
    localparam int CYC_W = 12;
    localparam int SEL_W = 4;
    localparam int QD    = 512;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trace_en = 1'b0;
    logic             full_en = 1'b0;
    logic             mini_en = 1'b0;
    logic             cyc_en = 1'b0;
    logic [SEL_W-1:0] mini_sel = '0;
    logic [CYC_W-1:0] cyc_thresh = '0;
    logic             sync_req = 1'b0;
    logic [TS_W-1:0]  tsc = '0;
    logic [CRY_W-1:0] ctc = '0;
    logic             pkt_ready = 1'b1;
    logic             pkt_valid;
    logic [1:0]       pkt_type;
    logic [TS_W-1:0]  pkt_payload;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int q_n = 0;
    logic [1:0]      q_type [QD];
    logic [TS_W-1:0] q_pay  [QD];

    always #2 clk = ~clk;

    trace_timing_sched #(.TS_W(TS_W), .CRY_W(CRY_W), .CYC_W(CYC_W), .SEL_W(SEL_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .trace_en (trace_en), .full_en (full_en),
        .mini_en (mini_en), .cyc_en (cyc_en), .mini_sel (mini_sel),
        .cyc_thresh (cyc_thresh), .sync_req (sync_req), .tsc (tsc), .ctc (ctc),
        .pkt_ready (pkt_ready), .pkt_valid (pkt_valid), .pkt_type (pkt_type),
        .pkt_payload (pkt_payload)
    );

    // record every handshake; values seen at negedge are those the next posedge samples
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && pkt_valid && pkt_ready) begin
            if (q_n < QD) begin
                q_type[q_n] <= pkt_type;
                q_pay[q_n]  <= pkt_payload;
            end
            q_n <= q_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic quiesce();
        step(1);
        trace_en = 0; full_en = 0; mini_en = 0; cyc_en = 0;
        sync_req = 0; pkt_ready = 1;
        step(6);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R1 valid low after reset", pkt_valid, 0);
    endtask

    task automatic t_full_start();
        int base;
        quiesce();
        base = q_n;
        tsc = 32'h1234_5678;
        full_en = 1; trace_en = 1;
        step(8);
        chk(q_n - base == 1, "R2 one full packet on enable", q_n - base, 1);
        chk(q_type[base] == 2'd1, "R2 type code", q_type[base], 1);
        chk(q_pay[base] == 32'h1234_5678, "R2 payload is tsc", q_pay[base], 32'h1234_5678);
    endtask

    task automatic t_sync();
        int base;
        quiesce();
        trace_en = 1;
        step(4);
        base = q_n;
        sync_req = 1; step(1); sync_req = 0;
        step(6);
        chk(q_n == base, "R9 sync with full_en low gives nothing", q_n - base, 0);
        full_en = 1;
        step(6);
        chk(q_n == base, "R2 full_en after rise gives nothing", q_n - base, 0);
        tsc = 32'hCAFE_0042;
        sync_req = 1; step(1); sync_req = 0;
        step(6);
        chk(q_n - base == 1, "R3 sync gives one packet", q_n - base, 1);
        chk(q_pay[base] == 32'hCAFE_0042 && q_type[base] == 2'd1, "R3 payload and type",
            q_pay[base], 32'hCAFE_0042);
    endtask

    task automatic t_mini();
        int base;
        quiesce();
        ctc = 16'h0000; mini_sel = 4'd6;
        step(2);
        trace_en = 1; mini_en = 1;
        step(3);
        base = q_n;
        ctc = 16'h0040; step(5);
        ctc = 16'h0FC0; step(5);
        ctc = 16'h0F80; step(5);
        mini_sel = 4'd10; step(2);
        ctc = 16'h0B80; step(5);
        chk(q_n - base == 3, "R4 three flips three packets", q_n - base, 3);
        chk(q_type[base] == 2'd2 && q_pay[base] == 32'h1, "R4 slice at bit 6", q_pay[base], 1);
        chk(q_pay[base+1] == 32'h3E, "R4 slice 0xF80 at bit 6", q_pay[base+1], 32'h3E);
        chk(q_pay[base+2] == 32'h2, "R4 slice at bit 10", q_pay[base+2], 2);
        mini_en = 0; step(1);
        base = q_n;
        ctc = 16'h0F80; step(6);
        chk(q_n == base, "R9 mini disabled ignores flip", q_n - base, 0);
    endtask

    task automatic t_cyc();
        int base;
        int n;
        bit ok;
        quiesce();
        trace_en = 1; cyc_thresh = 12'd5;
        step(2);
        base = q_n;
        cyc_en = 1;
        step(22);
        cyc_en = 0;
        step(4);
        n = q_n - base;
        chk(n >= 3 && n <= 5, "R5 cycle packet count over 22 clocks", n, 4);
        ok = 1;
        for (int i = 0; i < n; i++) ok &= (q_type[base+i] == 2'd3) && (q_pay[base+i] == 32'd5);
        chk(ok, "R5 every cycle packet carries threshold", q_pay[base], 5);
    endtask

    task automatic t_stall();
        int base;
        logic [TS_W-1:0] held;
        bit steady;
        quiesce();
        pkt_ready = 0; trace_en = 1; cyc_thresh = 12'd3; cyc_en = 1;
        step(10);
        @(negedge clk);
        chk(pkt_valid && pkt_type == 2'd3 && pkt_payload == 32'd3, "R8 stalled cycle packet shown",
            pkt_payload, 3);
        held = pkt_payload;
        steady = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            steady &= pkt_valid && pkt_type == 2'd3 && pkt_payload == held;
        end
        chk(steady, "R8 packet held while ready low", pkt_payload, held);
        step(4200);
        base = q_n;
        pkt_ready = 1;
        step(3);
        cyc_en = 0;
        step(6);
        chk(q_pay[base] == 32'd3, "R8 stalled packet delivered", q_pay[base], 3);
        chk(q_type[base+1] == 2'd3 && q_pay[base+1] == 32'hFFF, "R6 saturated count",
            q_pay[base+1], 32'hFFF);
    endtask

    task automatic t_prio();
        int base;
        quiesce();
        ctc = 16'h0000; mini_sel = 4'd2;
        step(2);
        base = q_n;
        pkt_ready = 0; tsc = 32'hA5A5_0001; cyc_thresh = 12'd2;
        full_en = 1; mini_en = 1; cyc_en = 1; trace_en = 1; ctc = 16'h0004;
        step(6);
        pkt_ready = 1;
        step(8);
        cyc_en = 0; mini_en = 0; full_en = 0;
        step(5);
        chk(q_type[base] == 2'd1, "R7 first is full timestamp", q_type[base], 1);
        chk(q_type[base+1] == 2'd2, "R7 second is mini", q_type[base+1], 2);
        chk(q_type[base+2] == 2'd3, "R7 third is cycle", q_type[base+2], 3);
    endtask

    task automatic t_trace_off();
        int base;
        quiesce();
        full_en = 1; mini_en = 1; cyc_en = 1; cyc_thresh = 12'd2; mini_sel = 4'd0;
        base = q_n;
        sync_req = 1; step(1); sync_req = 0;
        ctc = ctc ^ 16'h0001; step(10);
        chk(q_n == base, "R10 nothing issued with tracing off", q_n - base, 0);
        @(negedge clk);
        chk(!pkt_valid, "R1 valid low while tracing off", pkt_valid, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        t_reset();
        t_full_start();
        t_sync();
        t_mini();
        t_cyc();
        t_stall();
        t_prio();
        t_trace_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule